// File: doc/BRIEF.md
# I2C status and clock-stretch controller

This block sits between the bus-side units of an I2C controller (the byte shifter with its START/STOP generator, the arbitration monitor and the address comparator) and the software-facing register file. Each of those units reports a finished bus step as a one-cycle event pulse. The controller chooses the most urgent pulse and raises an interrupt flag. It then publishes an 8-bit status code that names the step in the context of the current transfer, and it asks the SCL pad to pull the clock low. The transfer stays frozen until software has seen the code.

Software answers by strobing a flag-clear input. The flag falls, SCL is released and the status register returns to a fixed no-information code. A small internal tracker records whether this controller currently owns the bus and in which role the transfer runs: master transmit, master receive, slave receive, general-call receive or slave transmit. The same event pulse can therefore map to different codes. Two control inputs decide how the block answers on the bus: an acknowledge enable and a general-call enable. Each one changes which address matches are accepted and which codes are reported for received data.

Top module: `i2c_stat_stretch`

## Requirements
- R1: While reset is held and right after it is released, the interrupt flag and the SCL hold request are 0 and the status reads 0xF8 (no information).
- R2: An accepted event sets the interrupt flag and the SCL hold request on the clock edge at which it is sampled. Both then stay at 1 until software clears them or the block is disabled.
- R3: The status shows the event's code starting one cycle after the flag rises. It shows 0xF8 in every cycle that follows a cycle with the flag clear, and every code it shows has bits [2:0] equal to zero.
- R4: A flag-clear strobe sampled while the flag is set drops the flag and the SCL hold request at that edge, and the status returns to 0xF8 one cycle later.
- R5: A START event reports 0x08 when the bus is not owned and 0x10 (repeated START) when a START was already reported with no STOP, arbitration loss or disable since.
- R6: An address-done event is accepted only directly after a START code. It reports 0x18 for write with ACK, 0x20 for write with NACK, 0x40 for read with ACK and 0x48 for read with NACK, where read means ev_rw_i=1 and ACK means ev_ack_i=1.
- R7: In master transmit, a data-done event reports 0x28 on ACK and 0x30 on NACK (ev_ack_i). In master receive it reports 0x50 when ack_en_i=1 and 0x58 when ack_en_i=0.
- R8: An address match is accepted only when ack_en_i=1, and a general-call match (ev_general_i=1) also needs gc_en_i=1. The codes are 0x60 for own address with write, 0xA8 for own address with read and 0x70 for general call. A match that is not accepted leaves the flag at 0.
- R9: In slave receive, data-done reports 0x80 or 0x88 (ack_en_i 1 or 0), or 0x90 or 0x98 after a general-call match. In slave transmit it reports 0xB8 on ACK and 0xC0 on NACK (ev_ack_i).
- R10: Arbitration loss reports 0x38 and wins over any event in the same cycle. It also drops bus ownership, so the next START reports 0x08.
- R11: Among the other events the order is START, then address match, then address done, then data done.
- R12: Events that arrive while the flag is set are discarded. The status keeps its code, and clearing the flag raises no new flag.
- R13: With en_i=0 the flag clears at the next edge, events are ignored and the role and ownership tracker is reset.
- R14: A STOP event raises no flag. It clears ownership and role, after which a data-done event is ignored and a START reports 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable |
| ack_en_i | input | 1 | Acknowledge enable (answer own address, ACK received data) |
| gc_en_i | input | 1 | General-call recognition enable |
| clr_i | input | 1 | Software flag-clear strobe |
| ev_start_i | input | 1 | START condition sent |
| ev_stop_i | input | 1 | STOP condition sent |
| ev_addr_done_i | input | 1 | Master address byte finished |
| ev_data_done_i | input | 1 | Data byte finished |
| ev_match_i | input | 1 | Incoming address matched |
| ev_arb_lost_i | input | 1 | Arbitration lost |
| ev_rw_i | input | 1 | Direction bit of the address byte (1 = read) |
| ev_ack_i | input | 1 | Acknowledge bit seen on the bus (1 = ACK) |
| ev_general_i | input | 1 | Match was the general-call address |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| scl_hold_o | output | 1 | Request to pull SCL low |

## Verification
On every cycle the assertions check the timing relations between the flag, SCL hold and status. The no-information code must follow a clear flag, a rising flag must bring a real code one cycle later, and codes must keep their three-bit alignment. The flag must be sticky until it is cleared, the clear strobe and the disable must release it, and a code must not change while the flag stays set. They also check that arbitration loss reports 0x38. Only the directed scenarios can show the mapping from context to code: START versus repeated START, the four address outcomes, data codes that depend on the role and the acknowledge enable, and the general-call gating. The scenarios also cover priority between events that arrive together, tracker resets by STOP, arbitration loss and disable, and events that are discarded while software is busy.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

  localparam int STAT_W = 8;
  typedef logic [STAT_W-1:0] stat_t;

  // status codes, low three bits always zero
  localparam stat_t ST_NONE        = 8'hF8;
  localparam stat_t ST_START       = 8'h08;
  localparam stat_t ST_RSTART      = 8'h10;
  localparam stat_t ST_MT_SLA_ACK  = 8'h18;
  localparam stat_t ST_MT_SLA_NACK = 8'h20;
  localparam stat_t ST_MT_DAT_ACK  = 8'h28;
  localparam stat_t ST_MT_DAT_NACK = 8'h30;
  localparam stat_t ST_ARB_LOST    = 8'h38;
  localparam stat_t ST_MR_SLA_ACK  = 8'h40;
  localparam stat_t ST_MR_SLA_NACK = 8'h48;
  localparam stat_t ST_MR_DAT_ACK  = 8'h50;
  localparam stat_t ST_MR_DAT_NACK = 8'h58;
  localparam stat_t ST_SR_SLA      = 8'h60;
  localparam stat_t ST_SR_GCALL    = 8'h70;
  localparam stat_t ST_SR_DAT_ACK  = 8'h80;
  localparam stat_t ST_SR_DAT_NACK = 8'h88;
  localparam stat_t ST_SR_GDAT_ACK = 8'h90;
  localparam stat_t ST_SR_GDAT_NAK = 8'h98;
  localparam stat_t ST_ST_SLA      = 8'hA8;
  localparam stat_t ST_ST_DAT_ACK  = 8'hB8;
  localparam stat_t ST_ST_DAT_NACK = 8'hC0;

  typedef enum logic [2:0] {
    MD_IDLE,
    MD_MSTART,
    MD_MTX,
    MD_MRX,
    MD_STX,
    MD_SRX,
    MD_SRX_GC
  } mode_e;

  // event slots, index order is priority order (0 = highest)
  localparam int NUM_EV   = 5;
  localparam int EV_ARB   = 0;
  localparam int EV_START = 1;
  localparam int EV_MATCH = 2;
  localparam int EV_ADDR  = 3;
  localparam int EV_DATA  = 4;

endpackage

// File: rtl/i2c_evt_decode.sv
module i2c_evt_decode
  import i2c_stat_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en_i,
  input  logic                          ack_en_i,
  input  logic                          gc_en_i,
  input  logic                          ev_start_i,
  input  logic                          ev_stop_i,
  input  logic                          ev_addr_done_i,
  input  logic                          ev_data_done_i,
  input  logic                          ev_match_i,
  input  logic                          ev_arb_lost_i,
  input  logic                          ev_rw_i,
  input  logic                          ev_ack_i,
  input  logic                          ev_general_i,
  input  logic                          take_i,
  input  logic [NUM_EV-1:0]             grant_i,
  output logic [NUM_EV-1:0]             req_o,
  output logic [NUM_EV-1:0][STAT_W-1:0] codes_o
);

  mode_e mode_q;
  logic  owned_q;

  logic  match_ok;
  logic  data_ok;
  stat_t data_code;

  assign match_ok = ev_match_i && ack_en_i && (!ev_general_i || gc_en_i);

  always_comb begin
    data_ok   = 1'b1;
    data_code = ST_NONE;
    unique case (mode_q)
      MD_MTX:    data_code = ev_ack_i ? ST_MT_DAT_ACK : ST_MT_DAT_NACK;
      MD_MRX:    data_code = ack_en_i ? ST_MR_DAT_ACK : ST_MR_DAT_NACK;
      MD_SRX:    data_code = ack_en_i ? ST_SR_DAT_ACK : ST_SR_DAT_NACK;
      MD_SRX_GC: data_code = ack_en_i ? ST_SR_GDAT_ACK : ST_SR_GDAT_NAK;
      MD_STX:    data_code = ev_ack_i ? ST_ST_DAT_ACK : ST_ST_DAT_NACK;
      default:   data_ok   = 1'b0;
    endcase
  end

  always_comb begin
    req_o = '0;
    req_o[EV_ARB]   = ev_arb_lost_i;
    req_o[EV_START] = ev_start_i;
    req_o[EV_MATCH] = match_ok;
    req_o[EV_ADDR]  = ev_addr_done_i && (mode_q == MD_MSTART);
    req_o[EV_DATA]  = ev_data_done_i && data_ok;

    codes_o = '0;
    codes_o[EV_ARB]   = ST_ARB_LOST;
    codes_o[EV_START] = owned_q ? ST_RSTART : ST_START;
    codes_o[EV_MATCH] = ev_general_i ? ST_SR_GCALL :
                        (ev_rw_i ? ST_ST_SLA : ST_SR_SLA);
    codes_o[EV_ADDR]  = ev_rw_i ? (ev_ack_i ? ST_MR_SLA_ACK : ST_MR_SLA_NACK)
                                : (ev_ack_i ? ST_MT_SLA_ACK : ST_MT_SLA_NACK);
    codes_o[EV_DATA]  = data_code;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      mode_q  <= MD_IDLE;
      owned_q <= 1'b0;
    end else if (take_i) begin
      if (grant_i[EV_ARB]) begin
        mode_q  <= MD_IDLE;
        owned_q <= 1'b0;
      end else if (grant_i[EV_START]) begin
        mode_q  <= MD_MSTART;
        owned_q <= 1'b1;
      end else if (grant_i[EV_MATCH]) begin
        mode_q  <= ev_general_i ? MD_SRX_GC : (ev_rw_i ? MD_STX : MD_SRX);
      end else if (grant_i[EV_ADDR]) begin
        mode_q  <= ev_rw_i ? MD_MRX : MD_MTX;
      end
    end else if (ev_stop_i) begin
      mode_q  <= MD_IDLE;
      owned_q <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][W-1:0] codes_i,
  output logic [N-1:0]        grant_o,
  output logic                any_o,
  output logic [W-1:0]        code_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign grant_o[g]  = req_i[g] && !seen[g];
    assign seen[g+1]   = seen[g] || req_i[g];
  end

  assign any_o = seen[N];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) code_o = codes_i[i];
    end
  end

endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   NO_INFO = 8'hF8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         clr_i,
  input  logic         any_i,
  input  logic [W-1:0] code_i,
  output logic         take_o,
  output logic         flag_o,
  output logic [W-1:0] status_o
);

  logic         flag_q;
  logic [W-1:0] held_q;
  logic [W-1:0] status_q;

  assign take_o = en_i && !flag_q && any_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      held_q <= NO_INFO;
    end else if (!en_i) begin
      flag_q <= 1'b0;
    end else if (take_o) begin
      flag_q <= 1'b1;
      held_q <= code_i;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  // status trails the flag by one cycle
  always_ff @(posedge clk) begin
    if (rst) status_q <= NO_INFO;
    else     status_q <= flag_q ? held_q : NO_INFO;
  end

  assign flag_o   = flag_q;
  assign status_o = status_q;

endmodule

// File: rtl/i2c_stat_stretch.sv
module i2c_stat_stretch
  import i2c_stat_pkg::*;
#(
  parameter logic [STAT_W-1:0] NO_INFO = ST_NONE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic              clr_i,
  input  logic              ev_start_i,
  input  logic              ev_stop_i,
  input  logic              ev_addr_done_i,
  input  logic              ev_data_done_i,
  input  logic              ev_match_i,
  input  logic              ev_arb_lost_i,
  input  logic              ev_rw_i,
  input  logic              ev_ack_i,
  input  logic              ev_general_i,
  output logic              irq_o,
  output logic [STAT_W-1:0] status_o,
  output logic              scl_hold_o
);

  logic [NUM_EV-1:0]             req;
  logic [NUM_EV-1:0][STAT_W-1:0] codes;
  logic [NUM_EV-1:0]             grant;
  logic                          any_req;
  logic [STAT_W-1:0]             sel_code;
  logic                          take;
  logic                          flag;

  i2c_evt_decode u_decode (
    .clk            (clk),
    .rst            (rst),
    .en_i           (en_i),
    .ack_en_i       (ack_en_i),
    .gc_en_i        (gc_en_i),
    .ev_start_i     (ev_start_i),
    .ev_stop_i      (ev_stop_i),
    .ev_addr_done_i (ev_addr_done_i),
    .ev_data_done_i (ev_data_done_i),
    .ev_match_i     (ev_match_i),
    .ev_arb_lost_i  (ev_arb_lost_i),
    .ev_rw_i        (ev_rw_i),
    .ev_ack_i       (ev_ack_i),
    .ev_general_i   (ev_general_i),
    .take_i         (take),
    .grant_i        (grant),
    .req_o          (req),
    .codes_o        (codes)
  );

  i2c_evt_prio #(.N(NUM_EV), .W(STAT_W)) u_prio (
    .req_i   (req),
    .codes_i (codes),
    .grant_o (grant),
    .any_o   (any_req),
    .code_o  (sel_code)
  );

  i2c_flag_ctrl #(.W(STAT_W), .NO_INFO(NO_INFO)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .clr_i    (clr_i),
    .any_i    (any_req),
    .code_i   (sel_code),
    .take_o   (take),
    .flag_o   (flag),
    .status_o (status_o)
  );

  assign irq_o      = flag;
  assign scl_hold_o = flag;

endmodule

// File: rtl/i2c_stat_stretch_chk.sv
module i2c_stat_stretch_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_i,
  input logic       clr_i,
  input logic       ev_start_i,
  input logic       ev_arb_lost_i,
  input logic       irq_o,
  input logic [7:0] status_o,
  input logic       scl_hold_o
);

  assert_code_align_R3: assert property (@(posedge clk) disable iff (rst)
    status_o[2:0] == 3'b000);

  assert_no_info_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(irq_o) |-> status_o == 8'hF8);

  assert_code_valid_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |=> status_o != 8'hF8);

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (rst)
    en_i && !irq_o && ev_start_i |=> irq_o && scl_hold_o);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    irq_o && en_i && !clr_i |=> irq_o);

  assert_clear_release_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o && clr_i |=> !irq_o && !scl_hold_o);

  assert_arb_code_R10: assert property (@(posedge clk) disable iff (rst)
    en_i && !irq_o && ev_arb_lost_i |=> ##1 status_o == 8'h38);

  assert_busy_stable_R12: assert property (@(posedge clk) disable iff (rst)
    irq_o && $past(irq_o) && en_i && !clr_i |=> $stable(status_o));

  assert_disable_R13: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_o);

endmodule

bind i2c_stat_stretch i2c_stat_stretch_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .en_i          (en_i),
  .clr_i         (clr_i),
  .ev_start_i    (ev_start_i),
  .ev_arb_lost_i (ev_arb_lost_i),
  .irq_o         (irq_o),
  .status_o      (status_o),
  .scl_hold_o    (scl_hold_o)
);

// File: tb/sim_i2c_stat_stretch.sv
module sim_i2c_stat_stretch;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, en = 1'b0, ack_en = 1'b0, gc_en = 1'b0, clr = 1'b0;
  logic ev_start = 1'b0, ev_stop = 1'b0, ev_addr = 1'b0, ev_data = 1'b0;
  logic ev_match = 1'b0, ev_arb = 1'b0, ev_rw = 1'b0, ev_ack = 1'b0, ev_gen = 1'b0;
  logic       irq, scl;
  logic [7:0] st;

  int checks = 0;
  int failures = 0;

  i2c_stat_stretch u0 (
    .clk(clk), .rst(rst), .en_i(en), .ack_en_i(ack_en), .gc_en_i(gc_en),
    .clr_i(clr), .ev_start_i(ev_start), .ev_stop_i(ev_stop),
    .ev_addr_done_i(ev_addr), .ev_data_done_i(ev_data), .ev_match_i(ev_match),
    .ev_arb_lost_i(ev_arb), .ev_rw_i(ev_rw), .ev_ack_i(ev_ack),
    .ev_general_i(ev_gen), .irq_o(irq), .status_o(st), .scl_hold_o(scl)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic drop_pulses();
    ev_start = 0; ev_stop = 0; ev_addr = 0; ev_data = 0; ev_match = 0; ev_arb = 0;
  endtask

  // pulses already driven: check flag, code one cycle later, then clear
  task automatic expect_event(string tag, logic [7:0] code);
    step(); drop_pulses();
    chk({tag, " R2 flag"}, {7'd0, irq}, 8'd1);
    chk({tag, " R2 scl"}, {7'd0, scl}, 8'd1);
    chk({tag, " R3 status lag"}, st, 8'hF8);
    step();
    chk({tag, " code"}, st, code);
    clr = 1; step(); clr = 0;
    chk({tag, " R4 flag clr"}, {7'd0, irq}, 8'd0);
    chk({tag, " R4 scl clr"}, {7'd0, scl}, 8'd0);
    step();
    chk({tag, " R4 status back"}, st, 8'hF8);
  endtask

  task automatic expect_none(string tag);
    step(); drop_pulses();
    chk({tag, " no flag"}, {7'd0, irq}, 8'd0);
    step();
    chk({tag, " no info"}, st, 8'hF8);
  endtask

  task automatic t_master();
    ev_start = 1; expect_event("R5 start", 8'h08);
    ev_addr = 1; ev_rw = 0; ev_ack = 1; expect_event("R6 addr W ack", 8'h18);
    ev_data = 1; ev_ack = 1; expect_event("R7 tx data ack", 8'h28);
    ev_data = 1; ev_ack = 0; expect_event("R7 tx data nack", 8'h30);
    ev_start = 1; expect_event("R5 repeated start", 8'h10);
    ev_addr = 1; ev_rw = 1; ev_ack = 0; expect_event("R6 addr R nack", 8'h48);
    ev_start = 1; expect_event("R5 repeated start 2", 8'h10);
    ev_addr = 1; ev_rw = 1; ev_ack = 1; expect_event("R6 addr R ack", 8'h40);
    ack_en = 1; ev_data = 1; expect_event("R7 rx data ack", 8'h50);
    ack_en = 0; ev_data = 1; expect_event("R7 rx data nack", 8'h58);
    ev_stop = 1; expect_none("R14 stop");
    ev_data = 1; expect_none("R14 data after stop");
    ev_addr = 1; expect_none("R6 addr without start");
    ev_start = 1; expect_event("R14 start after stop", 8'h08);
    ev_addr = 1; ev_rw = 0; ev_ack = 0; expect_event("R6 addr W nack", 8'h20);
    ev_arb = 1; expect_event("R10 arb lost", 8'h38);
    ev_start = 1; expect_event("R10 start after arb", 8'h08);
    ev_stop = 1; expect_none("R14 stop 2");
  endtask

  task automatic t_slave();
    ack_en = 1; gc_en = 0;
    ev_match = 1; ev_gen = 1; expect_none("R8 gcall disabled");
    ev_gen = 0; ev_rw = 0; ev_match = 1; expect_event("R8 own write", 8'h60);
    ev_data = 1; expect_event("R9 srx ack", 8'h80);
    ack_en = 0; ev_data = 1; expect_event("R9 srx nack", 8'h88);
    ack_en = 1; gc_en = 1; ev_match = 1; ev_gen = 1; expect_event("R8 gcall", 8'h70);
    ev_gen = 0; ev_data = 1; expect_event("R9 gc data ack", 8'h90);
    ack_en = 0; ev_data = 1; expect_event("R9 gc data nack", 8'h98);
    ev_match = 1; ev_rw = 1; expect_none("R8 match ack off");
    ack_en = 1; ev_match = 1; ev_rw = 1; expect_event("R8 own read", 8'hA8);
    ev_data = 1; ev_ack = 1; expect_event("R9 stx ack", 8'hB8);
    ev_data = 1; ev_ack = 0; expect_event("R9 stx nack", 8'hC0);
    ev_stop = 1; expect_none("R14 slave stop");
    gc_en = 0; ev_rw = 0;
  endtask

  task automatic t_priority();
    ack_en = 1;
    ev_arb = 1; ev_start = 1; ev_match = 1; expect_event("R10 arb wins", 8'h38);
    ev_start = 1; ev_match = 1; expect_event("R11 start over match", 8'h08);
    ev_match = 1; ev_addr = 1; ev_rw = 0; ev_ack = 1;
    expect_event("R11 match over addr", 8'h60);
    ev_stop = 1; expect_none("R11 cleanup stop");
  endtask

  task automatic t_busy();
    ev_start = 1; step(); drop_pulses();
    chk("R12 flag up", {7'd0, irq}, 8'd1);
    ev_arb = 1; step(); drop_pulses();
    chk("R12 status kept", st, 8'h08);
    step();
    chk("R12 status still", st, 8'h08);
    clr = 1; step(); clr = 0;
    chk("R12 cleared", {7'd0, irq}, 8'd0);
    step();
    chk("R12 no queued event", {7'd0, irq}, 8'd0);
    chk("R12 no info", st, 8'hF8);
    ev_start = 1; expect_event("R12 ownership kept", 8'h10);
    ev_stop = 1; expect_none("R12 cleanup stop");
  endtask

  task automatic t_enable();
    ev_start = 1; step(); drop_pulses();
    chk("R13 flag up", {7'd0, irq}, 8'd1);
    en = 0; step();
    chk("R13 flag drop", {7'd0, irq}, 8'd0);
    chk("R13 scl drop", {7'd0, scl}, 8'd0);
    ev_start = 1; expect_none("R13 ignored while off");
    en = 1;
    ev_start = 1; expect_event("R13 tracker reset", 8'h08);
    ev_stop = 1; expect_none("R13 cleanup stop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset irq", {7'd0, irq}, 8'd0);
    chk("R1 reset scl", {7'd0, scl}, 8'd0);
    chk("R1 reset status", st, 8'hF8);
    rst = 0; en = 1; step();
    chk("R1 after reset status", st, 8'hF8);
    chk("R1 after reset irq", {7'd0, irq}, 8'd0);
    t_master();
    t_slave();
    t_priority();
    t_busy();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule